// File: doc/BRIEF.md
# Interrupt Request Capture and Acknowledge Unit

This unit collects interrupt requests on a parameterised set of input lines (eight by default) and turns them into a single request toward the processor. It also answers the processor's two-pulse acknowledge with a vector. A mode input selects how every line is sensed. With the mode input high, a line requests for as long as it is held high. With the mode input low, a line requests only after a low-to-high transition on it. Each pending request still follows its input line until the acknowledge freezes the choice.

Line 0 has the highest priority and the last line has the lowest. A mask input blocks individual lines. Lines at or below the priority of the highest-priority service routine in progress are held off until that routine ends, so routines nest. The end of the first acknowledge pulse picks the winning line and marks it in service. The second pulse presents a vector made of a base value with the line number appended.

If the requesting line has gone low by the time the first pulse ends, the unit still completes the handshake. In that case it returns the lowest-priority line number as a default and leaves the in-service state unchanged. Software can therefore tell a glitch from a genuine request on that line. An end-of-interrupt strobe retires the highest-priority routine in service.

Top module: `irqCaptureTop`

## Requirements
- R1: After reset, isrOut, irrOut, intReq, vecValid and vecOut are all zero.
- R2: With levelMode=1, irrOut bit i equals irqIn bit i, and a high unmasked line raises intReq.
- R3: With levelMode=0, a line raises a request only after a rising edge. A line that stays high after its routine is retired raises no new request until it falls and rises again.
- R4: With levelMode=1, a line that is still high after end-of-interrupt raises intReq again.
- R5: A first acknowledge pulse (ackIn high, then low) ends at the first clock edge where ackIn is seen low. At that edge the lowest-numbered line that is pending, unmasked and eligible wins, and its isrOut bit is set.
- R6: vecValid is high only while the second ackIn pulse is high. During that time vecOut = {vecBase, line number}, with the line number in the low 3 bits. At all other times vecOut is zero.
- R7: If no line qualifies when the first pulse ends, including when the request dropped before that edge, the vector carries line 7 and isrOut is left unchanged.
- R8: A genuine line-7 request that wins the acknowledge sets isrOut bit 7.
- R9: A line whose maskIn bit is 1 does not raise intReq and cannot win an acknowledge.
- R10: A one-cycle eoiIn pulse clears the lowest-numbered set bit of isrOut.
- R11: While isrOut bit k is the lowest set bit, only lines numbered below k raise intReq or win an acknowledge.
- R12: With levelMode=0, the winning line's irrOut bit is cleared at the end of the first acknowledge pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| levelMode | input | 1 | 1: high level requests; 0: rising edge requests |
| irqIn | input | 8 | Request lines, bit 0 highest priority |
| maskIn | input | 8 | 1 blocks the corresponding line |
| ackIn | input | 1 | Acknowledge pulses from the processor, active high |
| eoiIn | input | 1 | End-of-interrupt strobe, one cycle |
| vecBase | input | 5 | Upper bits of the returned vector |
| intReq | output | 1 | Interrupt request to the processor |
| irrOut | output | 8 | Pending requests |
| isrOut | output | 8 | In-service bits, for status reads |
| vecValid | output | 1 | Vector is being presented |
| vecOut | output | 8 | Vector: base and line number |

## Verification
The unit has three kinds of result, and each is due at a different time.

- **Request state.** intReq and irrOut follow the line in the same cycle in level mode. In edge mode they follow one clock edge after the rise, because the edge is registered.
- **In-service bits.** isrOut changes on the edge that ends the first pulse, or on the edge that takes eoiIn.
- **Vector.** The vector appears on the edge that first sees the second pulse high.

The bench drives every input on the falling clock edge and samples one falling edge after the rising edge that produces each result. The acknowledge driver queues the expected vector and in-service value, and a monitor compares them on the falling edge where vecValid is seen.

// File: rtl/irqCapturePkg.sv
package irqCapturePkg;

  typedef enum logic [1:0] {
    ACK_IDLE   = 2'd0,
    ACK_FIRST  = 2'd1,
    ACK_GAP    = 2'd2,
    ACK_SECOND = 2'd3
  } ackState_e;

  typedef struct packed {
    logic resolve;   // end of first acknowledge pulse: freeze the winner
    logic eoi;       // retire highest-priority in-service bit
    logic showVec;   // second pulse active: present the vector
  } ctrlStrobes_t;

endpackage

// File: rtl/irqAckCtrl.sv
module irqAckCtrl
  import irqCapturePkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ackIn,
  input  logic         eoiIn,
  output ctrlStrobes_t strobes
);

  ackState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ACK_IDLE:   if (ackIn)  stateNext = ACK_FIRST;
      ACK_FIRST:  if (!ackIn) stateNext = ACK_GAP;
      ACK_GAP:    if (ackIn)  stateNext = ACK_SECOND;
      ACK_SECOND: if (!ackIn) stateNext = ACK_IDLE;
      default:                stateNext = ACK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ACK_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    strobes.resolve = (state == ACK_FIRST) && !ackIn;
    strobes.eoi     = (state == ACK_IDLE) && eoiIn;
    strobes.showVec = (state == ACK_SECOND);
  end

  AST_VEC_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.showVec |-> $past(ackIn)) else $error("vector shown without ack pulse"); // R6

  AST_RESOLVE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.resolve |=> !strobes.resolve) else $error("resolve repeated"); // R5

endmodule

// File: rtl/irqCaptureDp.sv
module irqCaptureDp
  import irqCapturePkg::*;
#(
  parameter int NUM_LINES = 8,
  localparam int LINE_W = $clog2(NUM_LINES)
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 levelMode,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [NUM_LINES-1:0] maskIn,
  input  ctrlStrobes_t         strobes,
  output logic                 intReq,
  output logic [NUM_LINES-1:0] irrOut,
  output logic [NUM_LINES-1:0] isrOut,
  output logic [LINE_W-1:0]    lineOut
);

  localparam logic [LINE_W-1:0] DEFAULT_LINE = LINE_W'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] irqPrev, armed, pending, eligible, cand;
  logic [NUM_LINES-1:0] isr, winOneHot, eoiClr, rising;
  logic [LINE_W-1:0]    winIdx, lineReg;
  logic                 anyCand;

  assign rising  = irqIn & ~irqPrev;
  // transparent request: follows the line until the acknowledge freezes it
  assign pending = levelMode ? irqIn : (armed & irqIn);

  // a line is eligible only if no equal-or-higher priority routine is in service
  always_comb begin
    logic seen;
    seen = 1'b0;
    for (int i = 0; i < NUM_LINES; i++) begin
      seen        = seen | isr[i];
      eligible[i] = ~seen;
    end
  end

  assign cand    = pending & ~maskIn & eligible;
  assign anyCand = |cand;

  always_comb begin
    winIdx = DEFAULT_LINE;
    for (int i = NUM_LINES - 1; i >= 0; i--)
      if (cand[i]) winIdx = LINE_W'(i);
  end

  assign winOneHot = anyCand ? (NUM_LINES'(1) << winIdx) : '0;
  assign eoiClr    = isr & (~isr + NUM_LINES'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irqPrev <= '0;
      armed   <= '0;
      isr     <= '0;
      lineReg <= '0;
    end else begin
      irqPrev <= irqIn;
      if (levelMode)
        armed <= '0;
      else
        armed <= (armed | rising) & ~(strobes.resolve ? winOneHot : '0);
      isr <= (isr & ~(strobes.eoi ? eoiClr : '0)) |
             (strobes.resolve ? winOneHot : '0);
      if (strobes.resolve)
        lineReg <= anyCand ? winIdx : DEFAULT_LINE;
    end
  end

  assign intReq  = anyCand;
  assign irrOut  = pending;
  assign isrOut  = isr;
  assign lineOut = lineReg;

  AST_DEFAULT_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.resolve && !anyCand |=> isr == $past(isr)) else $error("default changed isr"); // R7

  AST_GRANT_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.resolve && anyCand |=> (isr & $past(winOneHot)) == $past(winOneHot)) else $error("grant missing isr"); // R5

  AST_EDGE_CLEARS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.resolve && anyCand && !levelMode && !$isunknown(winOneHot)
      |=> (armed & $past(winOneHot)) == '0) else $error("edge request not cleared"); // R12

  AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.eoi && (isr != '0) |=> $countones(isr) + 1 == $countones($past(isr))) else $error("eoi cleared wrong count"); // R10

endmodule

// File: rtl/irqCaptureTop.sv
module irqCaptureTop
  import irqCapturePkg::*;
#(
  parameter int NUM_LINES  = 8,
  parameter int VEC_BASE_W = 5,
  localparam int LINE_W = $clog2(NUM_LINES),
  localparam int VEC_W  = VEC_BASE_W + LINE_W
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  levelMode,
  input  logic [NUM_LINES-1:0]  irqIn,
  input  logic [NUM_LINES-1:0]  maskIn,
  input  logic                  ackIn,
  input  logic                  eoiIn,
  input  logic [VEC_BASE_W-1:0] vecBase,
  output logic                  intReq,
  output logic [NUM_LINES-1:0]  irrOut,
  output logic [NUM_LINES-1:0]  isrOut,
  output logic                  vecValid,
  output logic [VEC_W-1:0]      vecOut
);

  ctrlStrobes_t      strobes;
  logic [LINE_W-1:0] lineNum;

  irqAckCtrl uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ackIn   (ackIn),
    .eoiIn   (eoiIn),
    .strobes (strobes)
  );

  irqCaptureDp #(.NUM_LINES(NUM_LINES)) uDp (
    .clk       (clk),
    .rst_n     (rst_n),
    .levelMode (levelMode),
    .irqIn     (irqIn),
    .maskIn    (maskIn),
    .strobes   (strobes),
    .intReq    (intReq),
    .irrOut    (irrOut),
    .isrOut    (isrOut),
    .lineOut   (lineNum)
  );

  assign vecValid = strobes.showVec;
  assign vecOut   = vecValid ? {vecBase, lineNum} : '0;

  AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    vecValid |-> vecOut[VEC_W-1:LINE_W] == vecBase) else $error("vector base wrong"); // R6

endmodule

// File: tb/sim_irqCaptureTop.sv
`timescale 1ns/1ps
module sim_irqCaptureTop;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       levelMode = 1'b1;
  logic [7:0] irqIn = '0;
  logic [7:0] maskIn = '0;
  logic       ackIn = 1'b0;
  logic       eoiIn = 1'b0;
  logic [4:0] vecBase = 5'b10101;
  logic       intReq, vecValid;
  logic [7:0] irrOut, isrOut, vecOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] vec;
    logic [7:0] isr;
    string      req;
  } expItem_t;
  expItem_t expQ[$];

  always #5 clk = ~clk;

  irqCaptureTop u0 (
    .clk(clk), .rst_n(rst_n), .levelMode(levelMode), .irqIn(irqIn),
    .maskIn(maskIn), .ackIn(ackIn), .eoiIn(eoiIn), .vecBase(vecBase),
    .intReq(intReq), .irrOut(irrOut), .isrOut(isrOut),
    .vecValid(vecValid), .vecOut(vecOut)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops an expected vector whenever one is presented
  always @(negedge clk) begin
    if (rst_n && vecValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R6 unexpected vector", {24'd0, vecOut}, 32'd0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        chk(vecOut == e.vec, e.req, {24'd0, vecOut}, {24'd0, e.vec});
        chk(isrOut == e.isr, e.req, {24'd0, isrOut}, {24'd0, e.isr});
      end
    end
  end

  // driver: full two-pulse acknowledge; lines in dropMask fall as the first pulse ends
  task automatic ackCycle(input logic [2:0] line, input logic [7:0] isrExp,
                          input logic [7:0] dropMask, input string req);
    expItem_t e;
    e.vec = {vecBase, line};
    e.isr = isrExp;
    e.req = req;
    expQ.push_back(e);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    irqIn = irqIn & ~dropMask;
    @(negedge clk);
    ackIn = 1'b1;
    @(negedge clk);
    ackIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseEoi();
    eoiIn = 1'b1;
    @(negedge clk);
    eoiIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(isrOut == 0 && irrOut == 0 && !intReq && !vecValid && vecOut == 0,
        "R1 reset", {isrOut, irrOut, 7'd0, intReq, vecOut}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 level request
    irqIn = 8'h08;
    @(negedge clk);
    chk(irrOut == 8'h08, "R2 irr follows", {24'd0, irrOut}, 32'h08);
    chk(intReq, "R2 intReq", {31'd0, intReq}, 32'd1);
    chk(vecOut == 0, "R6 idle vector zero", {24'd0, vecOut}, 32'd0);

    // R5 R6 acknowledge line 3
    ackCycle(3'd3, 8'h08, 8'h00, "R5 R6 line3 vector");
    chk(!vecValid && vecOut == 0, "R6 no vector after", {24'd0, vecOut}, 32'd0);

    // R11 lower line held off by in-service line 3
    irqIn = 8'h28;
    @(negedge clk);
    chk(!intReq, "R11 lower held off", {31'd0, intReq}, 32'd0);
    irqIn = 8'h2A;
    @(negedge clk);
    chk(intReq, "R11 higher passes", {31'd0, intReq}, 32'd1);
    ackCycle(3'd1, 8'h0A, 8'h00, "R11 nested line1");

    // R10 eoi clears highest-priority bit
    irqIn = 8'h28;
    pulseEoi();
    chk(isrOut == 8'h08, "R10 eoi first", {24'd0, isrOut}, 32'h08);
    pulseEoi();
    chk(isrOut == 8'h00, "R10 eoi second", {24'd0, isrOut}, 32'h00);
    // R4 level still high re-requests
    chk(intReq, "R4 level re-request", {31'd0, intReq}, 32'd1);
    ackCycle(3'd3, 8'h08, 8'h00, "R4 line3 again");
    irqIn = 8'h00;
    pulseEoi();

    // R9 mask
    maskIn = 8'h04;
    irqIn  = 8'h04;
    @(negedge clk);
    chk(!intReq, "R9 masked no req", {31'd0, intReq}, 32'd0);
    ackCycle(3'd7, 8'h00, 8'h00, "R9 masked gives default");
    irqIn = 8'h00;
    maskIn = 8'h00;

    // R7 spurious: line drops before first pulse ends
    irqIn = 8'h10;
    @(negedge clk);
    chk(intReq, "R7 pre req", {31'd0, intReq}, 32'd1);
    ackCycle(3'd7, 8'h00, 8'h10, "R7 spurious default");
    chk(isrOut == 8'h00, "R7 isr unchanged", {24'd0, isrOut}, 32'h00);

    // R8 genuine line 7
    irqIn = 8'h80;
    @(negedge clk);
    ackCycle(3'd7, 8'h80, 8'h00, "R8 genuine line7");
    ackCycle(3'd7, 8'h80, 8'h80, "R7 default during line7");
    chk(isrOut == 8'h80, "R7 isr7 kept", {24'd0, isrOut}, 32'h80);
    pulseEoi();
    chk(isrOut == 8'h00, "R10 eoi line7", {24'd0, isrOut}, 32'h00);

    // R3 R12 edge mode
    levelMode = 1'b0;
    irqIn = 8'h00;
    @(negedge clk);
    irqIn = 8'h04;
    @(negedge clk);
    chk(intReq && irrOut == 8'h04, "R3 edge request", {23'd0, intReq, irrOut}, 32'h104);
    ackCycle(3'd2, 8'h04, 8'h00, "R5 edge line2");
    chk(irrOut == 8'h00, "R12 edge irr cleared", {24'd0, irrOut}, 32'h00);
    pulseEoi();
    chk(!intReq, "R3 held high no re-request", {31'd0, intReq}, 32'd0);
    irqIn = 8'h00;
    @(negedge clk);
    irqIn = 8'h50;
    @(negedge clk);
    chk(intReq && irrOut == 8'h50, "R3 new edges", {23'd0, intReq, irrOut}, 32'h150);
    ackCycle(3'd4, 8'h10, 8'h00, "R5 edge priority line4");
    pulseEoi();
    ackCycle(3'd6, 8'h40, 8'h00, "R5 edge line6");
    pulseEoi();
    chk(isrOut == 8'h00 && !intReq, "R3 all retired", {23'd0, intReq, isrOut}, 32'h0);

    repeat (2) @(negedge clk);
    chk(expQ.size() == 0, "R6 all vectors seen", expQ.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule